// File: doc/BRIEF.md
# Set-Associative Translation Lookup with Address-Space Tags

This block holds a small set-associative table of page translations. Each entry is tagged with an address-space identifier. It answers one lookup per cycle. A 32-bit virtual address is split into a 20-bit page number and a 12-bit offset. The low page-number bits select a set, and every way of that set is compared in parallel. An entry matches when it is valid, its stored page number equals the lookup page number, and it is either marked global or tagged with the identifier presented alongside the lookup. The result is registered and appears one cycle after the request. It carries a hit flag, the physical page base, the entry's read/write/execute permissions, and a permission-denied flag for the requested access type.

Each entry is kept as a packed tag word and a data word. The tag word holds the page number in bits 31:12, the global flag in bit 11, the valid flag in bit 10 and the identifier in the low identifier-width bits. The data word holds the frame number and the three permission bits. Entries are loaded through a single write port that names the way directly. The set is taken from the low bits of the written page number. Walking page tables, choosing a victim and reporting faults belong to the surrounding logic.

Top module: `asid_tlb`

## Requirements
- R1: The page number is lookup address bits 31:12; the set is the page number masked by (entries per way − 1). Offset bits never affect the result, and an entry whose page number differs only in bits above the set index does not match.
- R2: An entry matches only when its valid flag is set, its page number equals the lookup page number, and its identifier equals the lookup identifier, unless R3 applies.
- R3: An entry written with the global flag set matches regardless of the lookup identifier.
- R4: Every way of the selected set is compared; a hit is reported whenever any way matches, whichever way holds the entry.
- R5: When more than one way matches, the result is taken from the lowest-numbered matching way.
- R6: On a hit, the physical page base output equals the entry's frame number shifted left by 12 with the low 12 bits zero. The permission output is the entry's bits, with bit 0 read, bit 1 write and bit 2 execute.
- R7: The access type is coded 0 read, 1 write, 2 fetch; code 3 is treated as a read. On a hit, the deny flag is set exactly when the entry lacks the permission bit that the access type needs.
- R8: On a miss, the hit flag, page base, permissions and deny flag are all zero.
- R9: Each response is registered: the response-valid output equals the request-valid input of the previous cycle. In a cycle after no request, every response output is zero.
- R10: After reset, every entry is invalid and every response output is zero.
- R11: A write takes effect at the next clock edge. A lookup in the same cycle sees the old contents. Only the named way and set change, and writing with the valid input low removes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one entry this cycle |
| wr_way | input | $clog2(WAYS) | Way to load |
| wr_vpn | input | 20 | Page number of the entry; low bits choose the set |
| wr_pid | input | PID_W | Identifier stored with the entry |
| wr_global | input | 1 | Entry matches any identifier |
| wr_valid | input | 1 | Valid flag stored with the entry |
| wr_pfn | input | PFN_W | Physical frame number |
| wr_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | PID_W | Current identifier |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 read |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A way matched |
| rsp_paddr | output | PFN_W+12 | Physical page base |
| rsp_perm | output | 3 | Permissions of the matching entry |
| rsp_deny | output | 1 | Hit, but the needed permission is absent |

## Verification
A wrong stored tag, a wrong set index or a broken identifier compare shows up one cycle after the next lookup of that page, either as a missing or false hit or as a page base belonging to another entry. A broken priority between ways appears only when the same page sits in two ways of one set, so that case is set up on purpose and then collapsed by invalidating the lower way. Random loads and lookups over a small pool of page numbers and identifiers make aliasing, global entries and replaced entries frequent. Each response is compared with a model of the table kept in the bench.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int TAG_G_BIT  = 11;
    localparam int TAG_V_BIT  = 10;
    localparam int PID_MAX_W  = 10;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    // Returns 1 when the permission set allows the access type.
    function automatic logic perm_allows(input logic [1:0] acc, input logic [2:0] perm);
        case (acc_e'(acc))
            ACC_STORE: perm_allows = perm[PERM_W];
            ACC_FETCH: perm_allows = perm[PERM_X];
            default:   perm_allows = perm[PERM_R];
        endcase
    endfunction

endpackage

// File: rtl/asid_tlb_way.sv
module asid_tlb_way #(
    parameter int SETS   = 8,
    parameter int DATA_W = 23,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_tag,
    output logic [DATA_W-1:0] rd_data
);

    logic [31:0]       tag_q  [SETS];
    logic [31:0]       tag_d  [SETS];
    logic [DATA_W-1:0] data_q [SETS];
    logic [DATA_W-1:0] data_d [SETS];

    always_comb begin
        tag_d  = tag_q;
        data_d = data_q;
        if (wr_en) begin
            tag_d[wr_idx]  = wr_tag;
            data_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s]  <= '0;
                data_q[s] <= '0;
            end
        end else begin
            tag_q  <= tag_d;
            data_q <= data_d;
        end
    end

    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = data_q[rd_idx];

endmodule

// File: rtl/asid_tlb_match.sv
module asid_tlb_match
    import asid_tlb_pkg::*;
#(
    parameter int PID_W = 8
) (
    input  logic [31:0]      tag,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [PID_W-1:0] lk_pid,
    output logic             match
);

    logic vpn_eq;
    logic pid_ok;

    always_comb begin
        vpn_eq = (tag[31:PAGE_SHIFT] == lk_vpn);
        pid_ok = tag[TAG_G_BIT] || (tag[PID_W-1:0] == lk_pid);
        match  = tag[TAG_V_BIT] && vpn_eq && pid_ok;
    end

endmodule

// File: rtl/asid_tlb_pick.sv
module asid_tlb_pick #(
    parameter int WAYS   = 2,
    parameter int DATA_W = 23
) (
    input  logic [WAYS-1:0]              hit_vec,
    input  logic [WAYS-1:0][DATA_W-1:0]  data_vec,
    output logic                         any_hit,
    output logic [DATA_W-1:0]            pick_data
);

    always_comb begin
        pick_data = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) pick_data = data_vec[w];
        end
        any_hit = |hit_vec;
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int WAYS    = 2,
    parameter int ENTRIES = 16,
    parameter int PID_W   = 8,
    parameter int PFN_W   = 20,
    localparam int SETS   = ENTRIES / WAYS,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int DATA_W = PFN_W + 3,
    localparam int PA_W   = PFN_W + PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic              wr_global,
    input  logic              wr_valid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [2:0]        wr_perm,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [1:0]        lk_acc,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [2:0]        rsp_perm,
    output logic              rsp_deny
);

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            deny;
        logic [2:0]      perm;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [31:0]                     new_tag;
    logic [DATA_W-1:0]               new_data;
    logic [VPN_W-1:0]                lk_vpn;
    logic [IDX_W-1:0]                lk_idx;
    logic [IDX_W-1:0]                wr_idx;
    logic [WAYS-1:0]                 hit_vec;
    logic [WAYS-1:0][DATA_W-1:0]     data_vec;
    logic                            any_hit;
    logic [DATA_W-1:0]               pick_data;

    always_comb begin
        new_tag                     = '0;
        new_tag[31:PAGE_SHIFT]      = wr_vpn;
        new_tag[TAG_G_BIT]          = wr_global;
        new_tag[TAG_V_BIT]          = wr_valid;
        new_tag[PID_W-1:0]          = wr_pid;
        new_data                    = {wr_pfn, wr_perm};
        wr_idx                      = wr_vpn[IDX_W-1:0];
        lk_vpn                      = lk_vaddr[VA_W-1:PAGE_SHIFT];
        lk_idx                      = lk_vpn[IDX_W-1:0];
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [31:0] rd_tag;

        asid_tlb_way #(
            .SETS   (SETS),
            .DATA_W (DATA_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_way == WAY_W'(g))),
            .wr_idx  (wr_idx),
            .wr_tag  (new_tag),
            .wr_data (new_data),
            .rd_idx  (lk_idx),
            .rd_tag  (rd_tag),
            .rd_data (data_vec[g])
        );

        asid_tlb_match #(
            .PID_W (PID_W)
        ) u_match (
            .tag    (rd_tag),
            .lk_vpn (lk_vpn),
            .lk_pid (lk_pid),
            .match  (hit_vec[g])
        );
    end

    asid_tlb_pick #(
        .WAYS   (WAYS),
        .DATA_W (DATA_W)
    ) u_pick (
        .hit_vec   (hit_vec),
        .data_vec  (data_vec),
        .any_hit   (any_hit),
        .pick_data (pick_data)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = lk_valid;
        if (lk_valid && any_hit) begin
            rsp_d.hit   = 1'b1;
            rsp_d.perm  = pick_data[2:0];
            rsp_d.paddr = {pick_data[DATA_W-1:3], {PAGE_SHIFT{1'b0}}};
            rsp_d.deny  = !perm_allows(lk_acc, pick_data[2:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_perm  = rsp_q.perm;
    assign rsp_deny  = rsp_q.deny;

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [1:0]      lk_acc,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [2:0]      rsp_perm,
    input logic            rsp_deny
);

    // R9
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(lk_valid));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_paddr == '0 && rsp_perm == '0 && !rsp_deny));

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_paddr == '0 && rsp_perm == '0 && !rsp_deny));

    // R6
    page_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_paddr[11:0] == 12'd0);

    // R7
    store_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(lk_acc) == 2'd1) |-> (rsp_deny == !rsp_perm[1]));

    // R7
    fetch_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(lk_acc) == 2'd2) |-> (rsp_deny == !rsp_perm[2]));

    // R7
    load_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && ($past(lk_acc) == 2'd0 || $past(lk_acc) == 2'd3)) |-> (rsp_deny == !rsp_perm[0]));

endmodule

bind asid_tlb asid_tlb_chk #(.PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_acc    (lk_acc),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_paddr (rsp_paddr),
    .rsp_perm  (rsp_perm),
    .rsp_deny  (rsp_deny)
);

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;

    localparam int WAYS = 2, ENTRIES = 16, PID_W = 8, PFN_W = 20;
    localparam int SETS = ENTRIES / WAYS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [0:0]        wr_way = '0;
    logic [19:0]       wr_vpn = '0;
    logic [PID_W-1:0]  wr_pid = '0;
    logic              wr_global = 1'b0;
    logic              wr_valid = 1'b0;
    logic [PFN_W-1:0]  wr_pfn = '0;
    logic [2:0]        wr_perm = '0;
    logic              lk_valid = 1'b0;
    logic [31:0]       lk_vaddr = '0;
    logic [PID_W-1:0]  lk_pid = '0;
    logic [1:0]        lk_acc = '0;
    logic              rsp_valid, rsp_hit, rsp_deny;
    logic [31:0]       rsp_paddr;
    logic [2:0]        rsp_perm;

    int n_checks = 0;
    int n_fails  = 0;

    // bench model of the table
    logic [19:0]      m_vpn  [WAYS][SETS];
    logic [PID_W-1:0] m_pid  [WAYS][SETS];
    logic             m_g    [WAYS][SETS];
    logic             m_v    [WAYS][SETS];
    logic [PFN_W-1:0] m_pfn  [WAYS][SETS];
    logic [2:0]       m_perm [WAYS][SETS];

    logic        e_hit, e_deny;
    logic [31:0] e_paddr;
    logic [2:0]  e_perm;

    always #4 clk = ~clk;

    asid_tlb #(.WAYS(WAYS), .ENTRIES(ENTRIES), .PID_W(PID_W), .PFN_W(PFN_W)) u_asid_tlb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_vpn(wr_vpn),
        .wr_pid(wr_pid), .wr_global(wr_global), .wr_valid(wr_valid), .wr_pfn(wr_pfn),
        .wr_perm(wr_perm), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
        .lk_acc(lk_acc), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_perm(rsp_perm), .rsp_deny(rsp_deny)
    );

    function automatic logic needs(input logic [1:0] acc, input logic [2:0] p);
        if (acc == 2'd1) return p[1];
        if (acc == 2'd2) return p[2];
        return p[0];
    endfunction

    task automatic predict(input logic [31:0] va, input logic [PID_W-1:0] pid, input logic [1:0] acc);
        int s;
        s = int'(va[12 +: 3]);
        e_hit = 0; e_deny = 0; e_paddr = '0; e_perm = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!e_hit && m_v[w][s] && m_vpn[w][s] == va[31:12] && (m_g[w][s] || m_pid[w][s] == pid)) begin
                e_hit   = 1;
                e_paddr = {m_pfn[w][s], 12'h000};
                e_perm  = m_perm[w][s];
                e_deny  = !needs(acc, m_perm[w][s]);
            end
        end
    endtask

    task automatic check(input string req);
        n_checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== e_hit || rsp_paddr !== e_paddr ||
            rsp_perm !== e_perm || rsp_deny !== e_deny) begin
            n_fails++;
            $display("FAIL %s: got v=%0b hit=%0b pa=%h perm=%0d deny=%0b, expected v=1 hit=%0b pa=%h perm=%0d deny=%0b",
                     req, rsp_valid, rsp_hit, rsp_paddr, rsp_perm, rsp_deny, e_hit, e_paddr, e_perm, e_deny);
        end
    endtask

    task automatic check_idle(input string req);
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_paddr !== '0 || rsp_perm !== '0 || rsp_deny !== 1'b0) begin
            n_fails++;
            $display("FAIL %s: got v=%0b hit=%0b pa=%h perm=%0d deny=%0b, expected all zero",
                     req, rsp_valid, rsp_hit, rsp_paddr, rsp_perm, rsp_deny);
        end
    endtask

    task automatic model_write(input int w, input logic [19:0] vpn, input logic [PID_W-1:0] pid,
                               input logic g, input logic v, input logic [PFN_W-1:0] pfn, input logic [2:0] p);
        int s;
        s = int'(vpn[2:0]);
        m_vpn[w][s] = vpn; m_pid[w][s] = pid; m_g[w][s] = g;
        m_v[w][s] = v; m_pfn[w][s] = pfn; m_perm[w][s] = p;
    endtask

    task automatic drive_write(input int w, input logic [19:0] vpn, input logic [PID_W-1:0] pid,
                               input logic g, input logic v, input logic [PFN_W-1:0] pfn, input logic [2:0] p);
        wr_en = 1; wr_way = 1'(w); wr_vpn = vpn; wr_pid = pid;
        wr_global = g; wr_valid = v; wr_pfn = pfn; wr_perm = p;
    endtask

    task automatic do_write(input int w, input logic [19:0] vpn, input logic [PID_W-1:0] pid,
                            input logic g, input logic v, input logic [PFN_W-1:0] pfn, input logic [2:0] p);
        drive_write(w, vpn, pid, g, v, pfn, p);
        @(negedge clk);
        wr_en = 0;
        model_write(w, vpn, pid, g, v, pfn, p);
    endtask

    task automatic do_lookup(input logic [31:0] va, input logic [PID_W-1:0] pid,
                             input logic [1:0] acc, input string req);
        lk_valid = 1; lk_vaddr = va; lk_pid = pid; lk_acc = acc;
        predict(va, pid, acc);
        @(negedge clk);
        lk_valid = 0;
        check(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s++)
                model_write(w, '0, '0, 0, 0, '0, '0);

        repeat (3) @(negedge clk);
        // R10: outputs zero during and right after reset
        check_idle("R10");
        rst_n = 1;
        @(negedge clk);
        check_idle("R10");
        do_lookup(32'h0000_0000, 8'h00, 2'd0, "R10");

        // basic hit, permissions and deny per access type
        do_write(0, 20'h12345, 8'h05, 0, 1, 20'hABCDE, 3'b011);
        do_lookup(32'h1234_5000, 8'h05, 2'd0, "R2");
        do_lookup(32'h1234_5FFF, 8'h05, 2'd1, "R1");
        do_lookup(32'h1234_5ABC, 8'h05, 2'd2, "R7");
        do_lookup(32'h1234_5010, 8'h05, 2'd3, "R7");
        do_lookup(32'h1234_5000, 8'h06, 2'd0, "R2");
        do_lookup(32'h1234_D000, 8'h05, 2'd0, "R1");
        @(negedge clk);
        check_idle("R9");

        // global entry in way 1
        do_write(1, 20'h00777, 8'h01, 1, 1, 20'h00042, 3'b100);
        do_lookup(32'h0077_7000, 8'h09, 2'd2, "R3");
        do_lookup(32'h0077_7000, 8'h01, 2'd0, "R6");

        // duplicate page in both ways: lowest way wins, then collapse way 0
        do_write(1, 20'h12345, 8'h05, 0, 1, 20'h11111, 3'b100);
        do_lookup(32'h1234_5000, 8'h05, 2'd2, "R5");
        do_write(0, 20'h12345, 8'h05, 0, 0, 20'hABCDE, 3'b011);
        do_lookup(32'h1234_5000, 8'h05, 2'd2, "R4");
        do_lookup(32'h0077_7000, 8'h03, 2'd1, "R11");

        // write and lookup in the same cycle: old contents seen
        drive_write(0, 20'h0BEEF, 8'h07, 0, 1, 20'h0F00D, 3'b111);
        lk_valid = 1; lk_vaddr = 32'h0BEE_F000; lk_pid = 8'h07; lk_acc = 2'd0;
        predict(lk_vaddr, lk_pid, lk_acc);
        @(negedge clk);
        wr_en = 0; lk_valid = 0;
        check("R11");
        model_write(0, 20'h0BEEF, 8'h07, 0, 1, 20'h0F00D, 3'b111);
        do_lookup(32'h0BEE_F123, 8'h07, 2'd1, "R11");

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [19:0] vpn;
            logic [PID_W-1:0] pid;
            vpn = 20'(((($urandom % 4) + 20'h100) << 3) | ($urandom % 8));
            pid = PID_W'($urandom % 4);
            if ($urandom % 3 == 0) begin
                do_write(int'($urandom % 2), vpn, pid, ($urandom % 6) == 0, ($urandom % 8) != 0,
                         PFN_W'($urandom), 3'($urandom));
            end else begin
                do_lookup({vpn, 12'($urandom)}, pid, 2'($urandom), "R4");
            end
        end
        @(negedge clk);
        check_idle("R9");

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule